// File: doc/BRIEF.md
# Interrupt Priority Stack Controller

This block keeps the processor's running interrupt priority together with a short history of the priorities that came before it. The history is four 2-bit levels packed into one 8-bit word; the live level sits in the two low bits. When an interrupt is taken, the word shifts up by one level and the new level enters at the bottom. An explicit set-priority command does the same with a software-chosen value. A restore command rotates the word back down by one level. A parallel load refills the whole word from data popped off the stack. The full word is always visible so that the surrounding core can push it.

The block also decides when a pending request is taken. It does so only at an end-of-instruction strobe, never after a privileged instruction, and only for a request whose level is strictly above the live priority. A software trap is the exception: the live priority never blocks it. Among several hardware requests, the one with the highest level wins. A command that arrives in the same cycle as an eligible strobe wins over the accept, and the decision is made again on the following cycle against the updated priority.

Control is a two-state machine. In `ST_RUN`, acceptance is tried at each non-privileged end-of-instruction strobe. `ST_RECHECK` is a one-cycle state entered when a command coincided with an eligible strobe. The transitions are:
- RUN to RECHECK: a command arrives together with an eligible strobe.
- RECHECK to RECHECK: another command arrives in the recheck cycle.
- Any state to RUN: every other case.

Top module: `ipstk_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the priority word reads 0x00 and no accept pulse is given.
- R2: On a hardware accept, the word becomes {previous word[5:0], accepted level}, so the old live level moves to bits 3:2 and the top two bits are dropped.
- R3: A hardware request is accepted only if its 2-bit level is strictly greater than the live priority in bits 1:0. A level-0 request is therefore never accepted.
- R4: A set-priority strobe with value n makes the word {previous word[5:0], n}.
- R5: A restore strobe makes the word {previous word[1:0], previous word[7:2]}, a rotate right by two bits.
- R6: A load strobe replaces the whole word with the 8-bit load value.
- R7: When several commands arrive together, load wins over set, and set wins over restore.
- R8: An accept is considered only on an end-of-instruction strobe with the privileged flag low, or in the recheck cycle. A strobe with the privileged flag high takes nothing.
- R9: A software trap at an eligible point is taken whatever the live priority, and it wins over hardware requests. The accept reports the trap flag, the reported level is the live priority, and the word becomes {previous word[5:0], previous word[1:0]}.
- R10: Among simultaneous hardware requests, the highest level wins. Ties go to the lowest source index, which is reported with the accept.
- R11: A command in the same cycle as an eligible point blocks the accept for that cycle. On the next cycle an accept is evaluated against the updated priority, with no new strobe needed.
- R12: The accept outputs are registered. Each accept shows them for one cycle, appearing together with the updated word in the cycle after the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Pending hardware request per source |
| irq_lvl | input | NSRC*PW | Level of each source, source i in bits [i*PW +: PW] |
| trap_req | input | 1 | Software trap pending, never priority-blocked |
| eoi | input | 1 | End-of-instruction strobe |
| priv | input | 1 | The finishing instruction is privileged |
| set_stb | input | 1 | Set-priority command |
| set_val | input | PW | Value for set-priority |
| rest_stb | input | 1 | Restore (rotate right) command |
| load_stb | input | 1 | Parallel load command |
| load_val | input | PW*DEPTH | Word popped off the stack |
| take | output | 1 | Accept pulse |
| take_lvl | output | PW | Level written by the accept |
| take_src | output | IW | Winning source index |
| take_trap | output | 1 | The accept was a software trap |
| ip_val | output | PW*DEPTH | Full priority word |

## Verification
The bench uses the default build: four request sources, 2-bit levels and a four-deep history. With these values, every level, every live priority and every position in the 8-bit word can be reached within a few hundred cycles. The four sources are enough to produce two-way and three-way ties, and the history depth is shallow enough that levels visibly fall off the top after repeated shifts and come back around on restores. Random traffic mixes commands, privileged strobes and traps, so back-to-back recheck cycles and commands that collide with each other occur many times.

// File: rtl/ipstk_pkg.sv
package ipstk_pkg;
    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RECHECK = 1'b1
    } ipstk_state_e;
endpackage

// File: rtl/ipstk_arb.sv
module ipstk_arb #(
    parameter int NSRC = 4,
    parameter int PW   = 2,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]    req,
    input  logic [NSRC*PW-1:0] lvl,
    output logic               any,
    output logic [PW-1:0]      best_lvl,
    output logic [IW-1:0]      best_idx
);
    // scan from the top index down; ">=" lets lower indices win ties
    always_comb begin
        any      = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i] && (!any || (lvl[i*PW +: PW] >= best_lvl))) begin
                any      = 1'b1;
                best_lvl = lvl[i*PW +: PW];
                best_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ipstk_next.sv
module ipstk_next #(
    parameter int PW    = 2,
    parameter int DEPTH = 4,
    localparam int REGW = PW * DEPTH
) (
    input  logic [REGW-1:0] cur,
    input  logic            load_stb,
    input  logic [REGW-1:0] load_val,
    input  logic            set_stb,
    input  logic [PW-1:0]   set_val,
    input  logic            rest_stb,
    input  logic            acc,
    input  logic [PW-1:0]   acc_lvl,
    output logic [REGW-1:0] nxt
);
    always_comb begin
        if (load_stb)
            nxt = load_val;
        else if (set_stb)
            nxt = {cur[REGW-PW-1:0], set_val};
        else if (rest_stb)
            nxt = {cur[PW-1:0], cur[REGW-1:PW]};
        else if (acc)
            nxt = {cur[REGW-PW-1:0], acc_lvl};
        else
            nxt = cur;
    end
endmodule

// File: rtl/ipstk_ctl.sv
module ipstk_ctl #(
    parameter int NSRC  = 4,
    parameter int PW    = 2,
    parameter int DEPTH = 4,
    localparam int REGW = PW * DEPTH,
    localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    irq_req,
    input  logic [NSRC*PW-1:0] irq_lvl,
    input  logic               trap_req,
    input  logic               eoi,
    input  logic               priv,
    input  logic               set_stb,
    input  logic [PW-1:0]      set_val,
    input  logic               rest_stb,
    input  logic               load_stb,
    input  logic [REGW-1:0]    load_val,
    output logic               take,
    output logic [PW-1:0]      take_lvl,
    output logic [IW-1:0]      take_src,
    output logic               take_trap,
    output logic [REGW-1:0]    ip_val
);
    import ipstk_pkg::*;

    ipstk_state_e    st_q, st_d;
    logic [REGW-1:0] ip_q, ip_d;
    logic            hw_any;
    logic [PW-1:0]   hw_lvl;
    logic [IW-1:0]   hw_idx;
    logic            cmd, eligible, hw_ok, acc;
    logic [PW-1:0]   acc_lvl;
    logic [PW-1:0]   live;

    assign live = ip_q[PW-1:0];
    assign cmd  = load_stb | set_stb | rest_stb;

    ipstk_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
        .req      (irq_req),
        .lvl      (irq_lvl),
        .any      (hw_any),
        .best_lvl (hw_lvl),
        .best_idx (hw_idx)
    );

    // state transitions and accept decision
    always_comb begin
        eligible = 1'b0;
        st_d     = ST_RUN;
        unique case (st_q)
            ST_RUN:     eligible = eoi & ~priv;
            ST_RECHECK: eligible = 1'b1;
            default:    eligible = 1'b0;
        endcase
        if (cmd && eligible)
            st_d = ST_RECHECK;
        hw_ok   = hw_any && (hw_lvl > live);
        acc     = eligible && !cmd && (trap_req || hw_ok);
        acc_lvl = trap_req ? live : hw_lvl;
    end

    ipstk_next #(.PW(PW), .DEPTH(DEPTH)) u_next (
        .cur      (ip_q),
        .load_stb (load_stb),
        .load_val (load_val),
        .set_stb  (set_stb),
        .set_val  (set_val),
        .rest_stb (rest_stb),
        .acc      (acc),
        .acc_lvl  (acc_lvl),
        .nxt      (ip_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
            ip_q <= '0;
        end else begin
            st_q <= st_d;
            ip_q <= ip_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take      <= 1'b0;
            take_lvl  <= '0;
            take_src  <= '0;
            take_trap <= 1'b0;
        end else begin
            take      <= acc;
            take_lvl  <= acc ? acc_lvl : '0;
            take_src  <= (acc && !trap_req) ? hw_idx : '0;
            take_trap <= acc && trap_req;
        end
    end

    assign ip_val = ip_q;
endmodule

// File: rtl/ipstk_chk.sv
module ipstk_chk #(
    parameter int PW    = 2,
    parameter int DEPTH = 4,
    localparam int REGW = PW * DEPTH
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     eoi,
    input logic                     priv,
    input logic                     set_stb,
    input logic [PW-1:0]            set_val,
    input logic                     rest_stb,
    input logic                     load_stb,
    input logic [REGW-1:0]          load_val,
    input logic                     take,
    input logic [PW-1:0]            take_lvl,
    input logic                     take_trap,
    input logic [REGW-1:0]          ip_val,
    input ipstk_pkg::ipstk_state_e  st_q
);
    import ipstk_pkg::*;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ip_val == '0 && !take));

    // R2
    accept_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !take_trap) |-> ip_val == {$past(ip_val[REGW-PW-1:0]), take_lvl});

    // R3
    strict_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !take_trap) |-> take_lvl > $past(ip_val[PW-1:0]));

    // R4
    set_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !load_stb) |=> ip_val == {$past(ip_val[REGW-PW-1:0]), $past(set_val)});

    // R5
    restore_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_stb && !set_stb && !load_stb) |=>
            ip_val == {$past(ip_val[PW-1:0]), $past(ip_val[REGW-1:PW])});

    // R6
    load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> ip_val == $past(load_val));

    // R8
    eligible_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(st_q) == ST_RECHECK || $past(eoi && !priv)));

    // R11
    recheck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RECHECK) |-> !take);
endmodule

bind ipstk_ctl ipstk_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoi       (eoi),
    .priv      (priv),
    .set_stb   (set_stb),
    .set_val   (set_val),
    .rest_stb  (rest_stb),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .take      (take),
    .take_lvl  (take_lvl),
    .take_trap (take_trap),
    .ip_val    (ip_val),
    .st_q      (st_q)
);

// File: tb/ipstk_ctl_test.sv
module ipstk_ctl_test;
    localparam int NSRC = 4;
    localparam int PW   = 2;
    localparam int DEPTH = 4;
    localparam int REGW = PW * DEPTH;
    localparam int IW   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NSRC-1:0]    irq_req = '0;
    logic [NSRC*PW-1:0] irq_lvl = '0;
    logic               trap_req = 1'b0;
    logic               eoi = 1'b0;
    logic               priv = 1'b0;
    logic               set_stb = 1'b0;
    logic [PW-1:0]      set_val = '0;
    logic               rest_stb = 1'b0;
    logic               load_stb = 1'b0;
    logic [REGW-1:0]    load_val = '0;
    logic               take;
    logic [PW-1:0]      take_lvl;
    logic [IW-1:0]      take_src;
    logic               take_trap;
    logic [REGW-1:0]    ip_val;

    int n_chk = 0;
    int n_err = 0;
    int cyc_n = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ipstk_ctl #(.NSRC(NSRC), .PW(PW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .trap_req(trap_req), .eoi(eoi), .priv(priv), .set_stb(set_stb),
        .set_val(set_val), .rest_stb(rest_stb), .load_stb(load_stb),
        .load_val(load_val), .take(take), .take_lvl(take_lvl),
        .take_src(take_src), .take_trap(take_trap), .ip_val(ip_val)
    );

    // bench reference built from the requirement text
    logic [REGW-1:0] m_ip = '0;
    bit              m_rchk = 1'b0;
    logic            m_take = 1'b0;
    logic [PW-1:0]   m_lvl = '0;
    logic [IW-1:0]   m_src = '0;
    logic            m_trap = 1'b0;

    always @(posedge clk) begin
        bit ok_point;
        bit any_cmd;
        bit found;
        int wl;
        int wi;
        cyc_n++;
        if (!rst_n) begin
            m_ip = '0; m_rchk = 0; m_take = 0; m_lvl = '0; m_src = '0; m_trap = 0;
        end else begin
            ok_point = m_rchk || (eoi && !priv);
            any_cmd  = load_stb || set_stb || rest_stb;
            found = 0; wl = 0; wi = 0;
            for (int i = 0; i < NSRC; i++) begin
                if (irq_req[i] && (!found || int'(irq_lvl[i*PW +: PW]) > wl)) begin
                    found = 1; wl = int'(irq_lvl[i*PW +: PW]); wi = i;
                end
            end
            m_take = 0; m_lvl = '0; m_src = '0; m_trap = 0;
            if (ok_point && !any_cmd) begin
                if (trap_req) begin
                    m_take = 1; m_trap = 1; m_lvl = m_ip[1:0];
                    m_ip = {m_ip[5:0], m_ip[1:0]};
                end else if (found && wl > int'(m_ip[1:0])) begin
                    m_take = 1; m_lvl = PW'(wl); m_src = IW'(wi);
                    m_ip = {m_ip[5:0], PW'(wl)};
                end
            end else if (load_stb)  m_ip = load_val;
            else if (set_stb)       m_ip = {m_ip[5:0], set_val};
            else if (rest_stb)      m_ip = {m_ip[1:0], m_ip[7:2]};
            m_rchk = any_cmd && ok_point;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk("R2 R4 R5 R6 word vs model", int'(ip_val), int'(m_ip));
        chk("R12 take vs model", int'(take), int'(m_take));
        chk("R10 src vs model", int'(take_src), int'(m_src));
        chk("R9 trap/lvl vs model", int'({take_trap, take_lvl}), int'({m_trap, m_lvl}));
    endtask

    task automatic clr();
        irq_req = '0; irq_lvl = '0; trap_req = 0; eoi = 0; priv = 0;
        set_stb = 0; set_val = '0; rest_stb = 0; load_stb = 0; load_val = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc_n > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected below 20000", cyc_n);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clr();
        @(negedge clk);
        chk("R1 reset word", int'(ip_val), 0);
        chk("R1 reset take", int'(take), 0);
        @(negedge clk);
        rst_n = 1;
        step();
        chk("R1 word after reset", int'(ip_val), 0);

        // R4 set to 2
        set_stb = 1; set_val = 2; step(); clr();
        chk("R4 set", int'(ip_val), 'h02);
        // R3 equal level blocked
        irq_req = 4'b0001; irq_lvl = 8'h02; eoi = 1; step();
        chk("R3 equal level refused", int'(take), 0);
        // R2 R10 higher level wins
        irq_req = 4'b0011; irq_lvl = 8'h0E; eoi = 1; step(); clr();
        chk("R2 accept", int'(take), 1);
        chk("R10 source", int'(take_src), 1);
        chk("R2 word", int'(ip_val), 'h0B);
        step();
        chk("R12 single pulse", int'(take), 0);
        // R5 restore
        rest_stb = 1; step(); clr();
        chk("R5 rotate", int'(ip_val), 'hC2);
        // R8 privileged defers
        irq_req = 4'b0001; irq_lvl = 8'h03; eoi = 1; priv = 1; step();
        chk("R8 privileged no take", int'(take), 0);
        priv = 0; step(); clr();
        chk("R8 taken after plain", int'(take), 1);
        chk("R8 word", int'(ip_val), 'h0B);
        // R6 load, R10 tie
        load_stb = 1; load_val = 8'h00; step(); clr();
        chk("R6 load", int'(ip_val), 0);
        irq_req = 4'b1100; irq_lvl = 8'hA0; eoi = 1; step(); clr();
        chk("R10 tie to lower index", int'(take_src), 2);
        chk("R10 tie word", int'(ip_val), 'h02);
        // R9 trap at priority 3
        load_stb = 1; load_val = 8'h03; step(); clr();
        trap_req = 1; irq_req = 4'b0001; irq_lvl = 8'h03; eoi = 1; step(); clr();
        chk("R9 trap taken", int'({take, take_trap}), 3);
        chk("R9 trap level", int'(take_lvl), 3);
        chk("R9 trap word", int'(ip_val), 'h0F);
        // R7 precedence
        load_stb = 1; load_val = 8'h55; set_stb = 1; set_val = 3; rest_stb = 1; step(); clr();
        chk("R7 load wins", int'(ip_val), 'h55);
        set_stb = 1; set_val = 0; rest_stb = 1; step(); clr();
        chk("R7 set wins", int'(ip_val), 'h54);
        // R11 recheck against new priority
        irq_req = 4'b0001; irq_lvl = 8'h01; eoi = 1; set_stb = 1; set_val = 1; step();
        chk("R11 blocked by command", int'(take), 0);
        chk("R11 set applied", int'(ip_val), 'h51);
        eoi = 0; set_stb = 0; step();
        chk("R11 recheck refuses equal", int'(take), 0);
        irq_lvl = 8'h02; eoi = 1; set_stb = 1; set_val = 1; step();
        chk("R11 word", int'(ip_val), 'h45);
        eoi = 0; set_stb = 0; step(); clr();
        chk("R11 recheck accepts", int'(take), 1);
        chk("R11 recheck word", int'(ip_val), 'h16);

        // constrained random traffic
        for (int k = 0; k < 2000; k++) begin
            irq_req  = NSRC'($urandom);
            irq_lvl  = (NSRC*PW)'($urandom);
            trap_req = ($urandom % 8) == 0;
            eoi      = ($urandom % 2) == 0;
            priv     = ($urandom % 4) == 0;
            set_stb  = ($urandom % 8) == 0;
            set_val  = PW'($urandom);
            rest_stb = ($urandom % 8) == 0;
            load_stb = ($urandom % 16) == 0;
            load_val = REGW'($urandom);
            step();
        end
        clr();
        finish_run();
    end
endmodule